// File: doc/BRIEF.md
# High-Memory Bank Window Mapper

This block decides where each CPU access to the top 12 KB of a bank ($D000 to $FFFF) is served from. The decision holds for two low banks ($00, $01) and two slow banks ($E0, $E1). Reads in that window come from ROM or from RAM. The lower 4 KB of the window ($D000 to $DFFF) can come from either of two RAM pools. Pool one lies 4 KB below pool two in the bank's linear RAM. The upper 8 KB always uses the same RAM. Writes are either allowed into RAM or blocked.

The mapping state changes in two ways. Any access to $C080 to $C08F, in any bank, acts as a soft switch. A dedicated state port can also load the ROM-read and pool bits. That port reads back those bits merged into the auxiliary switch byte supplied from outside. In bank $00, RAM can come from auxiliary memory (physical bank $01) when the zero-page select input is active. A card-inhibit input takes the two low banks out of the scheme. They then show plain RAM, chosen by the auxiliary read and write selects, while the slow banks keep obeying the switches.

Each access produces a registered result one clock later. The result gives a source code, a RAM write permission, a 24-bit physical read address and a 24-bit physical write address.

Top module: `lc_bank_mapper`

## Requirements
- R1: After reset, window reads come from ROM, RAM writes are permitted, and pool two is selected, so the state read-back shows bit 3 = 1 and bit 2 = 1.
- R2: Only accesses whose 16-bit address masked with $FFF0 equals $C080 change the switch state, whatever the bank. Other accesses, including writes into the window, leave both the mapping and the read-back unchanged.
- R3: With address bit 3 of the last switch access at 0, pool two is used and a $Dxxx access maps to the same offset. With bit 3 at 1, pool one is used and the RAM offset is the address minus $1000.
- R4: Switch address bits [1:0] equal to 00 or 11 select RAM for reads. Values 01 or 10 select ROM, and a ROM read address is bank $FF with the unchanged 16-bit offset. Source codes: 0 none, 1 ROM, 2 RAM.
- R5: Write permission is set by a read of an odd switch address that directly follows another read of an odd switch address. Any even switch access clears both the permission and the arming. An odd switch write clears the arming and leaves the permission as it is.
- R6: $E000 to $FFFF maps to the same offset in the RAM bank, whatever the pool selection.
- R7: Banks other than $00, $01, $E0 and $E1, and addresses below $D000, give source 0, no write permission and zero addresses.
- R8: In bank $00, the switch-mapped RAM is physical bank $01 when the zero-page select is 1, and bank $00 otherwise.
- R9: With card-inhibit set, window accesses in banks $00 and $01 give source RAM with write permission. Bank $00 reads come from bank $01 if the auxiliary read select is 1, and bank $00 writes go to bank $01 if the auxiliary write select is 1. Banks $E0 and $E1 still follow the switches.
- R10: A state-port write loads ROM-read from data bit 1 and pool two from data bit 0. The read-back equals the auxiliary byte with bits 3 and 2 replaced by ROM-read and pool-two.
- R11: Mapping outputs appear on the clock edge that samples the access. A cycle without a valid access gives source 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | CPU access present this cycle |
| acc_read | input | 1 | 1 for read, 0 for write |
| acc_bank | input | 8 | Address bits 23:16 |
| acc_addr | input | 16 | Address bits 15:0 |
| aux_zp_sel | input | 1 | Bank $00 switched RAM from auxiliary memory |
| aux_rd_sel | input | 1 | Inhibited bank $00 reads from auxiliary memory |
| aux_wr_sel | input | 1 | Inhibited bank $00 writes to auxiliary memory |
| card_inhibit | input | 1 | Bit 6 of the shadow control byte |
| lc_we | input | 1 | State-port write strobe |
| lc_wdata | input | 2 | Bit 1 ROM-read, bit 0 pool two |
| aux_state | input | 8 | Auxiliary switch state byte |
| st_rdata | output | 8 | Merged state read-back |
| map_src | output | 2 | Read source code |
| map_wr_en | output | 1 | RAM write permitted |
| map_rd_addr | output | 24 | Physical read address |
| map_wr_addr | output | 24 | Physical write address |

## Verification
The hardest state to reach is the arming chain of write permission. The permission depends on the order of the last two switch accesses and on whether each was a read or a write, and a probe of the window must not disturb that history. The bench sweeps every ordered pair of the sixteen switch addresses, with the second access both as a read and as a write. After each pair it probes all four card banks, plus two outside banks, with the inhibit and auxiliary selects varied from the pair index. Directed sequences then cover a single odd read, a read-write-read chain, and switch hits from a non-zero bank.

// File: rtl/lcmap_pkg.sv
package lcmap_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_ROM  = 2'd1,
    SRC_RAM  = 2'd2
  } src_e;

  typedef struct packed {
    logic rd_rom;
    logic bank2;
    logic wr_ok;
  } lc_state_t;
endpackage

// File: rtl/lc_switch_ctrl.sv
module lc_switch_ctrl
  import lcmap_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] SW_BASE = 16'hC080,
  parameter int BANK_SEL_BIT = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_valid,
  input  logic              acc_read,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              lc_we,
  input  logic [1:0]        lc_wdata,
  output lc_state_t         st_q
);
  localparam logic [ADDR_W-1:0] SW_MASK = {{(ADDR_W-4){1'b1}}, 4'h0};

  logic sw_hit;
  logic odd_sel;
  logic pre_wr;

  assign sw_hit  = acc_valid && ((acc_addr & SW_MASK) == SW_BASE);
  assign odd_sel = acc_addr[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q.rd_rom <= 1'b1;
      st_q.bank2  <= 1'b1;
      st_q.wr_ok  <= 1'b1;
      pre_wr      <= 1'b0;
    end else if (sw_hit) begin
      st_q.rd_rom <= acc_addr[1] ^ acc_addr[0];
      st_q.bank2  <= ~acc_addr[BANK_SEL_BIT];
      if (!odd_sel) begin
        st_q.wr_ok <= 1'b0;
        pre_wr     <= 1'b0;
      end else if (acc_read) begin
        if (pre_wr) st_q.wr_ok <= 1'b1;
        pre_wr <= 1'b1;
      end else begin
        pre_wr <= 1'b0;
      end
    end else if (lc_we) begin
      st_q.rd_rom <= lc_wdata[1];
      st_q.bank2  <= lc_wdata[0];
    end
  end

  // R5: permission only rises after an odd read that found the chain armed
  assert_wr_arm_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(st_q.wr_ok) |-> $past(sw_hit && acc_read && odd_sel));

  // R5: an even switch access removes write permission
  assert_wr_block_R5: assert property (@(posedge clk) disable iff (rst)
    (sw_hit && !odd_sel) |=> !st_q.wr_ok);

  // R2: no switch hit and no port write keeps every state bit
  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!sw_hit && !lc_we) |=> ($stable(st_q) && $stable(pre_wr)));
endmodule

// File: rtl/lc_window_map.sv
module lc_window_map
  import lcmap_pkg::*;
#(
  parameter int BANK_W = 8,
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] WIN_BASE  = 16'hD000,
  parameter logic [ADDR_W-1:0] HI_BASE   = 16'hE000,
  parameter logic [ADDR_W-1:0] POOL1_OFF = 16'h1000,
  parameter logic [BANK_W-1:0] ROM_BANK  = 8'hFF,
  parameter logic [BANK_W-1:0] FAST_BANK = 8'h00,
  parameter logic [BANK_W-1:0] SLOW_BANK = 8'hE0
) (
  input  logic                     acc_valid,
  input  logic [BANK_W-1:0]        acc_bank,
  input  logic [ADDR_W-1:0]        acc_addr,
  input  lc_state_t                st,
  input  logic                     card_inhibit,
  input  logic                     aux_zp_sel,
  input  logic                     aux_rd_sel,
  input  logic                     aux_wr_sel,
  output src_e                     src,
  output logic                     wr_en,
  output logic [BANK_W+ADDR_W-1:0] rd_addr,
  output logic [BANK_W+ADDR_W-1:0] wr_addr
);
  localparam logic [BANK_W-1:0] PAIR_MASK = {{(BANK_W-1){1'b1}}, 1'b0};
  localparam logic [BANK_W-1:0] AUX_BANK  = FAST_BANK | {{(BANK_W-1){1'b0}}, 1'b1};

  logic              low_pair, slow_pair, in_card, in_win, in_lo4k, is_fast0;
  logic [BANK_W-1:0] base_bank;
  logic [ADDR_W-1:0] ram_off;

  assign low_pair  = (acc_bank & PAIR_MASK) == FAST_BANK;
  assign slow_pair = (acc_bank & PAIR_MASK) == SLOW_BANK;
  assign in_card   = low_pair || slow_pair;
  assign in_win    = acc_addr >= WIN_BASE;
  assign in_lo4k   = acc_addr < HI_BASE;
  assign is_fast0  = acc_bank == FAST_BANK;
  assign base_bank = (is_fast0 && aux_zp_sel) ? AUX_BANK : acc_bank;
  assign ram_off   = (in_lo4k && !st.bank2) ? (acc_addr - POOL1_OFF) : acc_addr;

  always_comb begin
    src     = SRC_NONE;
    wr_en   = 1'b0;
    rd_addr = '0;
    wr_addr = '0;
    if (acc_valid && in_card && in_win) begin
      if (card_inhibit && low_pair) begin
        src     = SRC_RAM;
        wr_en   = 1'b1;
        rd_addr = {(is_fast0 && aux_rd_sel) ? AUX_BANK : acc_bank, acc_addr};
        wr_addr = {(is_fast0 && aux_wr_sel) ? AUX_BANK : acc_bank, acc_addr};
      end else begin
        src     = st.rd_rom ? SRC_ROM : SRC_RAM;
        wr_en   = st.wr_ok;
        rd_addr = st.rd_rom ? {ROM_BANK, acc_addr} : {base_bank, ram_off};
        wr_addr = {base_bank, ram_off};
      end
    end
  end
endmodule

// File: rtl/lc_bank_mapper.sv
module lc_bank_mapper
  import lcmap_pkg::*;
#(
  parameter int BANK_W = 8,
  parameter int ADDR_W = 16,
  parameter int STATE_W = 8,
  parameter int RDROM_POS = 3,
  parameter int BANK2_POS = 2,
  parameter logic [BANK_W-1:0] ROM_BANK = 8'hFF,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'hD000
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      acc_valid,
  input  logic                      acc_read,
  input  logic [BANK_W-1:0]         acc_bank,
  input  logic [ADDR_W-1:0]         acc_addr,
  input  logic                      aux_zp_sel,
  input  logic                      aux_rd_sel,
  input  logic                      aux_wr_sel,
  input  logic                      card_inhibit,
  input  logic                      lc_we,
  input  logic [1:0]                lc_wdata,
  input  logic [STATE_W-1:0]        aux_state,
  output logic [STATE_W-1:0]        st_rdata,
  output logic [1:0]                map_src,
  output logic                      map_wr_en,
  output logic [BANK_W+ADDR_W-1:0]  map_rd_addr,
  output logic [BANK_W+ADDR_W-1:0]  map_wr_addr
);
  localparam int PA_W = BANK_W + ADDR_W;
  localparam logic [STATE_W-1:0] LC_MASK =
    (STATE_W'(1) << RDROM_POS) | (STATE_W'(1) << BANK2_POS);

  lc_state_t       st;
  src_e            src_d, src_q;
  logic            wr_d;
  logic [PA_W-1:0] rd_d, wa_d;
  logic [STATE_W-1:0] lc_bits;

  lc_switch_ctrl #(.ADDR_W(ADDR_W)) u_sw (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_read(acc_read),
    .acc_addr(acc_addr), .lc_we(lc_we), .lc_wdata(lc_wdata), .st_q(st)
  );

  lc_window_map #(.BANK_W(BANK_W), .ADDR_W(ADDR_W), .ROM_BANK(ROM_BANK),
                  .WIN_BASE(WIN_BASE)) u_map (
    .acc_valid(acc_valid), .acc_bank(acc_bank), .acc_addr(acc_addr), .st(st),
    .card_inhibit(card_inhibit), .aux_zp_sel(aux_zp_sel),
    .aux_rd_sel(aux_rd_sel), .aux_wr_sel(aux_wr_sel),
    .src(src_d), .wr_en(wr_d), .rd_addr(rd_d), .wr_addr(wa_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q       <= SRC_NONE;
      map_wr_en   <= 1'b0;
      map_rd_addr <= '0;
      map_wr_addr <= '0;
    end else begin
      src_q       <= src_d;
      map_wr_en   <= wr_d;
      map_rd_addr <= rd_d;
      map_wr_addr <= wa_d;
    end
  end

  assign map_src  = src_q;
  assign lc_bits  = (STATE_W'(st.rd_rom) << RDROM_POS) | (STATE_W'(st.bank2) << BANK2_POS);
  assign st_rdata = (aux_state & ~LC_MASK) | lc_bits;

  // R4: a ROM read always targets the ROM bank at the CPU offset
  assert_rom_bank_R4: assert property (@(posedge clk) disable iff (rst)
    (src_q == SRC_ROM) |-> (map_rd_addr[PA_W-1:ADDR_W] == ROM_BANK));

  // R9: inhibited low banks give writable RAM on the next edge
  assert_inhibit_R9: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && card_inhibit && acc_bank[BANK_W-1:1] == '0 && acc_addr >= WIN_BASE)
    |=> (src_q == SRC_RAM && map_wr_en));

  // R11: an idle cycle yields no source on the following edge
  assert_idle_R11: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> (src_q == SRC_NONE && !map_wr_en));
endmodule

// File: tb/lc_bank_mapper_test.sv
module lc_bank_mapper_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic acc_valid = 0, acc_read = 1;
  logic [7:0] acc_bank = 0;
  logic [15:0] acc_addr = 0;
  logic aux_zp_sel = 0, aux_rd_sel = 0, aux_wr_sel = 0, card_inhibit = 0;
  logic lc_we = 0;
  logic [1:0] lc_wdata = 0;
  logic [7:0] aux_state = 0;
  logic [7:0] st_rdata;
  logic [1:0] map_src;
  logic map_wr_en;
  logic [23:0] map_rd_addr, map_wr_addr;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;
  logic m_rom, m_bank2, m_wr, m_pre;

  always #10 clk = ~clk;

  lc_bank_mapper uut (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_read(acc_read),
    .acc_bank(acc_bank), .acc_addr(acc_addr), .aux_zp_sel(aux_zp_sel),
    .aux_rd_sel(aux_rd_sel), .aux_wr_sel(aux_wr_sel), .card_inhibit(card_inhibit),
    .lc_we(lc_we), .lc_wdata(lc_wdata), .aux_state(aux_state), .st_rdata(st_rdata),
    .map_src(map_src), .map_wr_en(map_wr_en), .map_rd_addr(map_rd_addr),
    .map_wr_addr(map_wr_addr)
  );

  task automatic calc(input logic v, input logic [7:0] b, input logic [15:0] a,
                      output logic [1:0] es, output logic ew,
                      output logic [23:0] era, output logic [23:0] ewa);
    logic card, lowp;
    logic [7:0] bb;
    logic [15:0] off;
    card = (b == 8'h00) || (b == 8'h01) || (b == 8'hE0) || (b == 8'hE1);
    lowp = (b == 8'h00) || (b == 8'h01);
    es = 2'd0; ew = 0; era = 0; ewa = 0;
    if (v && card && a >= 16'hD000) begin
      if (card_inhibit && lowp) begin
        es = 2'd2; ew = 1;
        era = {(b == 8'h00) ? {7'd0, aux_rd_sel} : b, a};
        ewa = {(b == 8'h00) ? {7'd0, aux_wr_sel} : b, a};
      end else begin
        bb  = (b == 8'h00) ? {7'd0, aux_zp_sel} : b;
        off = (a < 16'hE000 && !m_bank2) ? a - 16'h1000 : a;
        es  = m_rom ? 2'd1 : 2'd2;
        ew  = m_wr;
        era = m_rom ? {8'hFF, a} : {bb, off};
        ewa = {bb, off};
      end
    end
  endtask

  function automatic string pick_tag(input logic [7:0] b, input logic [15:0] a);
    if (!((b == 8'h00) || (b == 8'h01) || (b == 8'hE0) || (b == 8'hE1)) || a < 16'hD000) return "R7";
    if (card_inhibit && (b == 8'h00 || b == 8'h01)) return "R9";
    if (b == 8'h00 && aux_zp_sel) return "R8";
    if (a < 16'hE000) return "R3";
    return "R6";
  endfunction

  task automatic do_acc(input logic v, input logic [7:0] b, input logic [15:0] a,
                        input logic rd, input string tag_in);
    logic [1:0] es; logic ew; logic [23:0] era, ewa;
    string tag;
    calc(v, b, a, es, ew, era, ewa);
    tag = (tag_in == "") ? pick_tag(b, a) : tag_in;
    acc_valid = v; acc_bank = b; acc_addr = a; acc_read = rd;
    @(posedge clk);
    @(negedge clk);
    acc_valid = 0;
    vectors++;
    if (map_src !== es || map_wr_en !== ew || map_rd_addr !== era || map_wr_addr !== ewa) begin
      miscompares++;
      $display("FAIL %s: %02x:%04x got src=%0d we=%0d rd=%06x wr=%06x exp src=%0d we=%0d rd=%06x wr=%06x",
               tag, b, a, map_src, map_wr_en, map_rd_addr, map_wr_addr, es, ew, era, ewa);
    end
    if (v && (a & 16'hFFF0) == 16'hC080) begin
      m_rom   = a[1] ^ a[0];
      m_bank2 = !a[3];
      if (!a[0]) begin m_wr = 0; m_pre = 0; end
      else if (rd) begin if (m_pre) m_wr = 1; m_pre = 1; end
      else m_pre = 0;
    end
  endtask

  task automatic check_rb(input string tag);
    logic [7:0] exp;
    exp = (aux_state & 8'hF3) | {4'd0, m_rom, m_bank2, 2'd0};
    vectors++;
    if (st_rdata !== exp) begin
      miscompares++;
      $display("FAIL %s: readback got %02x exp %02x", tag, st_rdata, exp);
    end
  endtask

  task automatic port_wr(input logic [1:0] d);
    lc_we = 1; lc_wdata = d;
    @(posedge clk); @(negedge clk);
    lc_we = 0;
    m_rom = d[1]; m_bank2 = d[0];
  endtask

  initial begin
    logic [7:0] banks [6];
    logic [15:0] addrs [6];
    banks = '{8'h00, 8'h01, 8'hE0, 8'hE1, 8'h02, 8'h7F};
    addrs = '{16'hD000, 16'hDFFF, 16'hE000, 16'hFFFF, 16'hCFFF, 16'h0400};
    m_rom = 1; m_bank2 = 1; m_wr = 1; m_pre = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    check_rb("R1");
    do_acc(1, 8'h00, 16'hD123, 1, "R1");
    do_acc(1, 8'hE1, 16'hF000, 1, "R1");
    // R4 read source per low bits
    do_acc(1, 8'h00, 16'hC080, 1, "R4"); do_acc(1, 8'hE0, 16'hD010, 1, "R4");
    do_acc(1, 8'h00, 16'hC081, 1, "R4"); do_acc(1, 8'hE0, 16'hD010, 1, "R4");
    do_acc(1, 8'h00, 16'hC082, 1, "R4"); do_acc(1, 8'hE0, 16'hD010, 1, "R4");
    do_acc(1, 8'h00, 16'hC083, 1, "R4"); do_acc(1, 8'hE0, 16'hD010, 1, "R4");
    // R5 arming chain
    do_acc(1, 8'h00, 16'hC08A, 1, "R5"); do_acc(1, 8'h00, 16'hC089, 1, "R5");
    do_acc(1, 8'h01, 16'hD800, 1, "R5");
    do_acc(1, 8'h00, 16'hC089, 1, "R5"); do_acc(1, 8'h01, 16'hD800, 1, "R5");
    do_acc(1, 8'h00, 16'hC080, 0, "R5"); do_acc(1, 8'h01, 16'hD800, 1, "R5");
    do_acc(1, 8'h00, 16'hC081, 1, "R5"); do_acc(1, 8'h00, 16'hC081, 0, "R5");
    do_acc(1, 8'h00, 16'hC081, 1, "R5"); do_acc(1, 8'h01, 16'hD800, 1, "R5");
    // R2 non-switch accesses, and a switch hit from a far bank
    do_acc(1, 8'h00, 16'hC090, 1, "R2"); do_acc(1, 8'h00, 16'hC07F, 0, "R2");
    do_acc(1, 8'h00, 16'hD000, 0, "R2"); do_acc(1, 8'h00, 16'hD000, 1, "R2");
    check_rb("R2");
    do_acc(1, 8'h42, 16'hC08B, 1, "R2"); do_acc(1, 8'h42, 16'hC08B, 1, "R2");
    do_acc(1, 8'h00, 16'hD000, 1, "R2");
    // R10 state port
    aux_state = 8'hFF; port_wr(2'b10); check_rb("R10");
    do_acc(1, 8'hE0, 16'hD100, 1, "R10");
    aux_state = 8'h00; port_wr(2'b01); check_rb("R10");
    do_acc(1, 8'hE0, 16'hD100, 1, "R10");
    // R11 idle cycle
    do_acc(1, 8'h00, 16'hE000, 1, "R11"); do_acc(0, 8'h00, 16'hE000, 1, "R11");
    // sweep over ordered switch pairs and probe patterns
    for (int i = 0; i < 16; i++)
      for (int j = 0; j < 16; j++)
        for (int k = 0; k < 2; k++) begin
          logic [7:0] n;
          n = 8'((i * 16 + j) * 2 + k);
          {card_inhibit, aux_zp_sel, aux_rd_sel, aux_wr_sel} = n[3:0] ^ n[7:4];
          aux_state = n ^ 8'h5A;
          do_acc(1, 8'h00, 16'hC080 | 16'(i), 1, "R5");
          do_acc(1, 8'hE1, 16'hC080 | 16'(j), k[0], "R5");
          check_rb("R10");
          for (int p = 0; p < 6; p++)
            do_acc(1, banks[p], addrs[(p + i + j) % 6], p[0], "");
        end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule